// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Command Decoder

This block sits behind a serial shift front-end and turns each completed 16-bit command word into register actions for two converter channels, A and B. Every channel holds a staging (input) code and a live (output) code, so software can stage a value and make it live later, stage and go live in one word, or make both channels live at once. A per-channel shutdown flag can be set by command and is released by any command that rewrites that channel's live code. A general-purpose logic level and the data-out edge selection bit for the front-end are also held here.

The front-end presents the word on `cmd_word` with a one-cycle `cmd_valid` pulse. A three-bit field at the top of the word picks the operation; its all-zero value turns the upper four data bits into an extended sub-command. A shutdown permit input gates entry into shutdown and, when it falls, wakes both channels at once. An asynchronous clear zeroes the codes only, while power-on reset returns everything to its default.

Top module: `dual_dac_cmd_decoder`

## Requirements
- R1: Word layout: bit 15 is A0, bit 14 is C1, bit 13 is C0, bits 12..3 are the 10-bit code (bit 12 the MSB, D9), bits 2..0 are padding and are ignored. A word with `cmd_valid` high at a rising clock edge takes effect on that edge and is visible on the outputs right after it.
- R2: Field {A0,C1,C0} = 3'b001 writes the code into staging A, 3'b101 into staging B; neither changes a live code.
- R3: Field 3'b011 (staging A) or 3'b111 (staging B) writes the code into that staging register and, in the same edge, copies both staging registers (including the new value) into their live codes.
- R4: Field 3'b010 writes the code into both live codes and both staging registers.
- R5: Field 3'b110 copies each staging register into its own live code.
- R6: With field 3'b000, bits 12..9 are a sub-command: 4'b001x copies staging A to live A only; 4'b101x copies staging B to live B only.
- R7: Field 3'b100 shuts down both channels; sub-command 4'b110x shuts down A and 4'b111x shuts down B; each takes effect only while `sd_allow` is high at that edge.
- R8: While `sd_allow` is low no shutdown is entered; a fall of `sd_allow` drives both shutdown outputs low without waiting for a clock edge, and they stay low when `sd_allow` returns high.
- R9: Shutdown keeps staging and live codes; staging writes do not end it; any command that writes a channel's live code ends that channel's shutdown.
- R10: Sub-command 4'b010x drives `user_out` low and 4'b011x high; 4'b1001 sets `dout_rise` to 1 and 4'b1000 to 0; 4'b000x changes nothing.
- R11: `clr_n` low zeroes all four codes without waiting for a clock edge; shutdown flags, `user_out` and `dout_rise` keep their values. After release the codes stay zero through two more edges.
- R12: `por_n` low sets all codes, shutdown outputs, `user_out` and `dout_rise` to 0; the block responds to commands from the third rising edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| clr_n | input | 1 | Code clear, asynchronous, active low |
| sd_allow | input | 1 | Shutdown permit; its fall wakes both channels |
| cmd_word | input | 16 | Completed command word from the serial front-end |
| cmd_valid | input | 1 | One-cycle strobe qualifying `cmd_word` |
| dac_a | output | 10 | Live code of channel A |
| dac_b | output | 10 | Live code of channel B |
| shut_a | output | 1 | Channel A shut down |
| shut_b | output | 1 | Channel B shut down |
| user_out | output | 1 | General-purpose logic level |
| dout_rise | output | 1 | Data-out edge select for the front-end (1 = rising) |

## Verification
The hardest situation to reach is a channel that sits in shutdown while its staging and live codes differ, because only then can the bench tell whether a wake restores the old live code, takes the staged one, or loses both. The stimulus shuts both channels, stages a new B code without waking B, then wakes each channel with a different command kind, and later drops the permit asynchronously and clears the codes in the middle of a clock period while a shutdown is held. A behavioural model tracks every register and is compared on each falling edge, so asynchronous effects are seen before the next rising edge.

// File: rtl/dual_dac_pkg.sv
package dual_dac_pkg;

  localparam int unsigned NCH     = 2;
  localparam int unsigned CH_A    = 0;
  localparam int unsigned CH_B    = 1;
  localparam int unsigned FIELD_W = 3;
  localparam int unsigned PAD_W   = 3;
  localparam int unsigned EXT_W   = 4;

  typedef enum logic [FIELD_W-1:0] {
    FLD_EXT      = 3'b000,
    FLD_STAGE_A  = 3'b001,
    FLD_DIRECT   = 3'b010,
    FLD_STG_A_GO = 3'b011,
    FLD_SLEEP    = 3'b100,
    FLD_STAGE_B  = 3'b101,
    FLD_RECALL   = 3'b110,
    FLD_STG_B_GO = 3'b111
  } field_e;

  typedef struct packed {
    logic wr_stage;
    logic wr_live;
    logic sleep_req;
  } ch_act_t;

  typedef struct packed {
    logic lvl_set;
    logic lvl_val;
    logic edge_set;
    logic edge_val;
  } glob_act_t;

endpackage

// File: rtl/dual_dac_rst_sync.sv
module dual_dac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/dual_dac_cmd_decode.sv
module dual_dac_cmd_decode
  import dual_dac_pkg::*;
#(
  parameter int unsigned CODE_W = 10
) (
  input  logic [CODE_W+FIELD_W+PAD_W-1:0] word,
  input  logic                            valid,
  output ch_act_t [NCH-1:0]               act,
  output glob_act_t                       gact,
  output logic [CODE_W-1:0]               code
);
  localparam int unsigned WORD_W = CODE_W + FIELD_W + PAD_W;
  localparam int unsigned CODE_HI = WORD_W - FIELD_W - 1;

  field_e             field;
  logic [EXT_W-1:0]   ext;

  assign field = field_e'(word[WORD_W-1 -: FIELD_W]);
  assign ext   = word[CODE_HI -: EXT_W];
  assign code  = word[CODE_HI -: CODE_W];

  // R1: padding bits below the code are never looked at
  always_comb begin
    act  = '0;
    gact = '0;
    if (valid) begin
      case (field)
        FLD_STAGE_A: act[CH_A].wr_stage = 1'b1;
        FLD_STAGE_B: act[CH_B].wr_stage = 1'b1;
        FLD_STG_A_GO: begin
          act[CH_A].wr_stage = 1'b1;
          act[CH_A].wr_live  = 1'b1;
          act[CH_B].wr_live  = 1'b1;
        end
        FLD_STG_B_GO: begin
          act[CH_B].wr_stage = 1'b1;
          act[CH_A].wr_live  = 1'b1;
          act[CH_B].wr_live  = 1'b1;
        end
        FLD_DIRECT: begin
          for (int i = 0; i < NCH; i++) begin
            act[i].wr_stage = 1'b1;
            act[i].wr_live  = 1'b1;
          end
        end
        FLD_RECALL: begin
          for (int i = 0; i < NCH; i++) act[i].wr_live = 1'b1;
        end
        FLD_SLEEP: begin
          for (int i = 0; i < NCH; i++) act[i].sleep_req = 1'b1;
        end
        FLD_EXT: begin
          casez (ext)
            4'b001?: act[CH_A].wr_live   = 1'b1;
            4'b101?: act[CH_B].wr_live   = 1'b1;
            4'b110?: act[CH_A].sleep_req = 1'b1;
            4'b111?: act[CH_B].sleep_req = 1'b1;
            4'b010?: begin gact.lvl_set  = 1'b1; gact.lvl_val  = 1'b0; end
            4'b011?: begin gact.lvl_set  = 1'b1; gact.lvl_val  = 1'b1; end
            4'b1001: begin gact.edge_set = 1'b1; gact.edge_val = 1'b1; end
            4'b1000: begin gact.edge_set = 1'b1; gact.edge_val = 1'b0; end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dual_dac_channel.sv
module dual_dac_channel
  import dual_dac_pkg::*;
#(
  parameter int unsigned CODE_W = 10
) (
  input  logic              clk,
  input  logic              code_rst_n,
  input  logic              flag_rst_n,
  input  ch_act_t           act,
  input  logic [CODE_W-1:0] code,
  input  logic              sd_allow,
  output logic [CODE_W-1:0] live,
  output logic              shut
);
  logic [CODE_W-1:0] stage_q, stage_d, live_q, live_d;
  logic              stage_en, live_en;
  logic              sleep_q, sleep_d, sleep_en;

  // next state
  always_comb begin
    stage_en = act.wr_stage;
    stage_d  = code;
    live_en  = act.wr_live;
    live_d   = act.wr_stage ? code : stage_q;   // R3: go-live sees the new stage value
    sleep_en = act.wr_live | ~sd_allow | (act.sleep_req & sd_allow);
    sleep_d  = act.sleep_req & sd_allow & ~act.wr_live;
  end

  // codes: cleared by clear or power-on
  always_ff @(posedge clk or negedge code_rst_n) begin
    if (!code_rst_n) begin
      stage_q <= '0;
      live_q  <= '0;
    end else begin
      if (stage_en) stage_q <= stage_d;
      if (live_en)  live_q  <= live_d;
    end
  end

  // shutdown flag: power-on only (R11)
  always_ff @(posedge clk or negedge flag_rst_n) begin
    if (!flag_rst_n)   sleep_q <= 1'b0;
    else if (sleep_en) sleep_q <= sleep_d;
  end

  assign live = live_q;
  assign shut = sleep_q & sd_allow;   // R8: permit fall wakes at once
endmodule

// File: rtl/dual_dac_cmd_decoder.sv
module dual_dac_cmd_decoder
  import dual_dac_pkg::*;
#(
  parameter int unsigned CODE_W      = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            por_n,
  input  logic                            clr_n,
  input  logic                            sd_allow,
  input  logic [CODE_W+FIELD_W+PAD_W-1:0] cmd_word,
  input  logic                            cmd_valid,
  output logic [CODE_W-1:0]               dac_a,
  output logic [CODE_W-1:0]               dac_b,
  output logic                            shut_a,
  output logic                            shut_b,
  output logic                            user_out,
  output logic                            dout_rise
);
  logic              por_sync_n, code_arst_n, code_rst_n;
  ch_act_t [NCH-1:0] act;
  glob_act_t         gact;
  logic [CODE_W-1:0] code;
  logic [CODE_W-1:0] live [NCH];
  logic [NCH-1:0]    shut;
  logic              lvl_q, edge_q;

  assign code_arst_n = por_n & clr_n;

  dual_dac_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk(clk), .arst_n(por_n), .srst_n(por_sync_n));

  dual_dac_rst_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk(clk), .arst_n(code_arst_n), .srst_n(code_rst_n));

  dual_dac_cmd_decode #(.CODE_W(CODE_W)) u_decode (
    .word(cmd_word), .valid(cmd_valid), .act(act), .gact(gact), .code(code));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dual_dac_channel #(.CODE_W(CODE_W)) u_ch (
      .clk(clk), .code_rst_n(code_rst_n), .flag_rst_n(por_sync_n),
      .act(act[g]), .code(code), .sd_allow(sd_allow),
      .live(live[g]), .shut(shut[g]));
  end

  // R10 / R12: global level and edge select
  always_ff @(posedge clk or negedge por_sync_n) begin
    if (!por_sync_n) begin
      lvl_q  <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      if (gact.lvl_set)  lvl_q  <= gact.lvl_val;
      if (gact.edge_set) edge_q <= gact.edge_val;
    end
  end

  assign dac_a     = live[CH_A];
  assign dac_b     = live[CH_B];
  assign shut_a    = shut[CH_A];
  assign shut_b    = shut[CH_B];
  assign user_out  = lvl_q;
  assign dout_rise = edge_q;
endmodule

// File: rtl/dual_dac_cmd_decoder_sva.sv
module dual_dac_cmd_decoder_sva #(
  parameter int unsigned CODE_W = 10
) (
  input logic              clk,
  input logic              por_sync_n,
  input logic              code_rst_n,
  input logic              sd_allow,
  input logic [CODE_W+5:0] cmd_word,
  input logic              cmd_valid,
  input logic [CODE_W-1:0] dac_a,
  input logic [CODE_W-1:0] dac_b,
  input logic              shut_a,
  input logic              shut_b,
  input logic              user_out,
  input logic              dout_rise
);
  localparam int unsigned TOP  = CODE_W + 5;
  localparam int unsigned CHI  = CODE_W + 2;

  logic [2:0] fld;
  logic [3:0] ext;
  assign fld = cmd_word[TOP -: 3];
  assign ext = cmd_word[CHI -: 4];

  p_stage_only_r2: assert property (@(posedge clk) disable iff (!code_rst_n)
    (cmd_valid && (fld == 3'b001 || fld == 3'b101)) |=> ($stable(dac_a) && $stable(dac_b)));

  p_direct_both_r4: assert property (@(posedge clk) disable iff (!code_rst_n)
    (cmd_valid && fld == 3'b010) |=>
      (dac_a == $past(cmd_word[CHI -: CODE_W]) && dac_b == $past(cmd_word[CHI -: CODE_W])));

  p_no_sleep_locked_r8: assert property (@(posedge clk) disable iff (!por_sync_n)
    !sd_allow |=> (!shut_a && !shut_b));

  p_level_high_r10: assert property (@(posedge clk) disable iff (!por_sync_n)
    (cmd_valid && fld == 3'b000 && ext[3:1] == 3'b011) |=> user_out);

  p_edge_rise_r10: assert property (@(posedge clk) disable iff (!por_sync_n)
    (cmd_valid && fld == 3'b000 && ext == 4'b1001) |=> dout_rise);
endmodule

bind dual_dac_cmd_decoder dual_dac_cmd_decoder_sva #(.CODE_W(CODE_W)) u_sva (
  .clk(clk), .por_sync_n(por_sync_n), .code_rst_n(code_rst_n),
  .sd_allow(sd_allow), .cmd_word(cmd_word), .cmd_valid(cmd_valid),
  .dac_a(dac_a), .dac_b(dac_b), .shut_a(shut_a), .shut_b(shut_b),
  .user_out(user_out), .dout_rise(dout_rise));

// File: tb/dual_dac_cmd_decoder_bench.sv
module dual_dac_cmd_decoder_bench;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        por_n = 1'b1;
  logic        clr_n = 1'b1;
  logic        sd_allow = 1'b1;
  logic [15:0] cmd_word = '0;
  logic        cmd_valid = 1'b0;
  logic [9:0]  dac_a, dac_b;
  logic        shut_a, shut_b, user_out, dout_rise;

  int checks = 0;
  int errors = 0;
  bit run = 0;
  bit done = 0;
  string cur_req = "R12";

  // behavioural reference state
  logic [9:0] stg_m [2];
  logic [9:0] liv_m [2];
  bit         slp_m [2];
  bit         lvl_m = 0, edg_m = 0;
  int         por_cnt = 0, clr_cnt = 0;

  always #4 clk = ~clk;

  dual_dac_cmd_decoder u_dual_dac_cmd_decoder (
    .clk(clk), .por_n(por_n), .clr_n(clr_n), .sd_allow(sd_allow),
    .cmd_word(cmd_word), .cmd_valid(cmd_valid), .dac_a(dac_a), .dac_b(dac_b),
    .shut_a(shut_a), .shut_b(shut_b), .user_out(user_out), .dout_rise(dout_rise));

  function automatic logic [15:0] mk(input logic [2:0] f, input logic [9:0] d, input logic [2:0] pad);
    return {f, d, pad};
  endfunction

  function automatic logic [15:0] sub(input logic [3:0] s);
    return {3'b000, s, 6'b0, 3'b000};
  endfunction

  // model update on every rising edge
  always @(posedge clk) begin
    bit dres;
    bit ws [2]; bit wl [2]; bit sr [2];
    logic [2:0] f; logic [3:0] e; logic [9:0] d;
    if (!por_n) begin
      for (int i = 0; i < 2; i++) begin stg_m[i] = 0; liv_m[i] = 0; slp_m[i] = 0; end
      lvl_m = 0; edg_m = 0; por_cnt = SYNC; clr_cnt = 0;
    end else if (por_cnt > 0) begin
      por_cnt--;
      for (int i = 0; i < 2; i++) begin stg_m[i] = 0; liv_m[i] = 0; slp_m[i] = 0; end
      lvl_m = 0; edg_m = 0;
    end else begin
      dres = !clr_n || clr_cnt > 0;
      if (!clr_n) clr_cnt = SYNC; else if (clr_cnt > 0) clr_cnt--;
      for (int i = 0; i < 2; i++) begin ws[i] = 0; wl[i] = 0; sr[i] = 0; end
      f = cmd_word[15:13]; e = cmd_word[12:9]; d = cmd_word[12:3];
      if (cmd_valid) begin
        if (f == 3'b001) ws[0] = 1;
        if (f == 3'b101) ws[1] = 1;
        if (f == 3'b011) begin ws[0] = 1; wl[0] = 1; wl[1] = 1; end
        if (f == 3'b111) begin ws[1] = 1; wl[0] = 1; wl[1] = 1; end
        if (f == 3'b010) begin ws[0] = 1; ws[1] = 1; wl[0] = 1; wl[1] = 1; end
        if (f == 3'b110) begin wl[0] = 1; wl[1] = 1; end
        if (f == 3'b100) begin sr[0] = 1; sr[1] = 1; end
        if (f == 3'b000) begin
          if (e[3:1] == 3'b001) wl[0] = 1;
          if (e[3:1] == 3'b101) wl[1] = 1;
          if (e[3:1] == 3'b110) sr[0] = 1;
          if (e[3:1] == 3'b111) sr[1] = 1;
          if (e[3:1] == 3'b010) lvl_m = 0;
          if (e[3:1] == 3'b011) lvl_m = 1;
          if (e == 4'b1001) edg_m = 1;
          if (e == 4'b1000) edg_m = 0;
        end
      end
      for (int i = 0; i < 2; i++) begin
        if (!sd_allow) slp_m[i] = 0;
        if (wl[i]) slp_m[i] = 0;
        else if (sr[i] && sd_allow) slp_m[i] = 1;
        if (dres) begin stg_m[i] = 0; liv_m[i] = 0; end
        else begin
          if (wl[i]) liv_m[i] = ws[i] ? d : stg_m[i];
          if (ws[i]) stg_m[i] = d;
        end
      end
    end
  end

  task automatic cmp(input string what, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (run) begin
      bit z;
      z = !por_n || !clr_n;
      cmp("dac_a", dac_a, z ? 10'd0 : liv_m[0]);
      cmp("dac_b", dac_b, z ? 10'd0 : liv_m[1]);
      cmp("shut_a", {9'd0, shut_a}, {9'd0, slp_m[0] & sd_allow & por_n});
      cmp("shut_b", {9'd0, shut_b}, {9'd0, slp_m[1] & sd_allow & por_n});
      cmp("user_out", {9'd0, user_out}, {9'd0, lvl_m & por_n});
      cmp("dout_rise", {9'd0, dout_rise}, {9'd0, edg_m & por_n});
    end
  end

  task automatic send(input logic [15:0] w);
    @(posedge clk); #2;
    cmd_word = w; cmd_valid = 1'b1;
    @(posedge clk); #2;
    cmd_valid = 1'b0; cmd_word = '0;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [9:0] act, input logic [9:0] exp);
    string save;
    save = cur_req; cur_req = req;
    cmp(what, act, exp);
    cur_req = save;
  endtask

  task automatic finish_up();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_up();
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin stg_m[i] = 0; liv_m[i] = 0; slp_m[i] = 0; end
    #1 por_n = 1'b0;
    run = 1;
    repeat (3) @(posedge clk);
    #2 por_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12: defaults after power-on
    chk("R12", "dac_a", dac_a, 10'd0);
    chk("R12", "user_out", {9'd0, user_out}, 10'd0);
    chk("R12", "dout_rise", {9'd0, dout_rise}, 10'd0);

    cur_req = "R2";
    send(mk(3'b001, 10'h155, 3'b111));
    chk("R2", "dac_a after stage A", dac_a, 10'h000);
    send(mk(3'b101, 10'h2AA, 3'b000));
    chk("R2", "dac_b after stage B", dac_b, 10'h000);

    cur_req = "R5";
    send(mk(3'b110, 10'h000, 3'b000));
    chk("R5", "dac_b recall", dac_b, 10'h2AA);
    chk("R1", "dac_a padding ignored", dac_a, 10'h155);

    cur_req = "R3";
    send(mk(3'b011, 10'h3FF, 3'b000));
    chk("R3", "dac_a stage+go A", dac_a, 10'h3FF);
    chk("R3", "dac_b stage+go A", dac_b, 10'h2AA);
    send(mk(3'b101, 10'h001, 3'b000));
    send(mk(3'b111, 10'h0F0, 3'b000));
    chk("R3", "dac_b stage+go B", dac_b, 10'h0F0);
    chk("R3", "dac_a stage+go B", dac_a, 10'h3FF);

    cur_req = "R6";
    send(mk(3'b001, 10'h123, 3'b000));
    send(sub(4'b0010));
    chk("R6", "dac_a single go", dac_a, 10'h123);
    chk("R6", "dac_b untouched", dac_b, 10'h0F0);
    send(mk(3'b101, 10'h321, 3'b000));
    send(sub(4'b1011));
    chk("R6", "dac_b single go", dac_b, 10'h321);

    cur_req = "R4";
    send(mk(3'b010, 10'h2C5, 3'b000));
    chk("R4", "dac_a direct", dac_a, 10'h2C5);
    send(mk(3'b110, 10'h000, 3'b000));
    chk("R4", "dac_b recall after direct", dac_b, 10'h2C5);

    cur_req = "R7";
    send(mk(3'b100, 10'h000, 3'b000));
    chk("R7", "shut_a both", {9'd0, shut_a}, 10'd1);
    chk("R9", "dac_a kept in shutdown", dac_a, 10'h2C5);
    cur_req = "R9";
    send(sub(4'b0010));
    chk("R9", "shut_a woken by go A", {9'd0, shut_a}, 10'd0);
    chk("R9", "shut_b still down", {9'd0, shut_b}, 10'd1);
    send(mk(3'b001, 10'h0AA, 3'b000));
    send(mk(3'b101, 10'h0BB, 3'b000));
    chk("R9", "shut_b stage no wake", {9'd0, shut_b}, 10'd1);
    chk("R9", "dac_b held", dac_b, 10'h2C5);
    send(sub(4'b1010));
    chk("R9", "dac_b staged value on wake", dac_b, 10'h0BB);
    chk("R9", "shut_b woken", {9'd0, shut_b}, 10'd0);
    cur_req = "R7";
    send(sub(4'b1100));
    chk("R7", "shut_a single", {9'd0, shut_a}, 10'd1);
    send(sub(4'b1110));
    chk("R7", "shut_b single", {9'd0, shut_b}, 10'd1);

    cur_req = "R8";
    @(posedge clk); #2 sd_allow = 1'b0;
    @(negedge clk);
    chk("R8", "shut_a async wake", {9'd0, shut_a}, 10'd0);
    chk("R8", "shut_b async wake", {9'd0, shut_b}, 10'd0);
    repeat (2) @(posedge clk);
    #2 sd_allow = 1'b1;
    @(negedge clk);
    chk("R8", "shut_a stays awake", {9'd0, shut_a}, 10'd0);
    @(posedge clk); #2 sd_allow = 1'b0;
    send(mk(3'b100, 10'h000, 3'b000));
    send(sub(4'b1100));
    @(posedge clk); #2 sd_allow = 1'b1;
    @(negedge clk);
    chk("R8", "locked sleep ignored", {9'd0, shut_a | shut_b}, 10'd0);

    cur_req = "R10";
    send(sub(4'b0110));
    chk("R10", "user_out high", {9'd0, user_out}, 10'd1);
    send(sub(4'b0100));
    chk("R10", "user_out low", {9'd0, user_out}, 10'd0);
    send(sub(4'b0111));
    send(sub(4'b1001));
    chk("R10", "dout_rise set", {9'd0, dout_rise}, 10'd1);
    send(sub(4'b0001));
    chk("R10", "nop user_out", {9'd0, user_out}, 10'd1);
    chk("R10", "nop dac_a", dac_a, 10'h2C5);
    send(sub(4'b1000));
    chk("R10", "dout_rise cleared", {9'd0, dout_rise}, 10'd0);
    send(sub(4'b1001));

    cur_req = "R11";
    send(mk(3'b100, 10'h000, 3'b000));
    @(posedge clk); #2 clr_n = 1'b0;
    @(negedge clk);
    chk("R11", "dac_a cleared at once", dac_a, 10'd0);
    chk("R11", "dac_b cleared at once", dac_b, 10'd0);
    chk("R11", "shut_a kept", {9'd0, shut_a}, 10'd1);
    chk("R11", "user_out kept", {9'd0, user_out}, 10'd1);
    chk("R11", "dout_rise kept", {9'd0, dout_rise}, 10'd1);
    repeat (2) @(posedge clk);
    #2 clr_n = 1'b1;
    repeat (4) @(negedge clk);
    send(mk(3'b110, 10'h000, 3'b000));
    chk("R11", "staging cleared", dac_a, 10'd0);
    chk("R9", "recall wakes", {9'd0, shut_a}, 10'd0);

    repeat (3) @(negedge clk);
    run = 0;
    finish_up();
  end
endmodule